// File: doc/BRIEF.md
# Two-Phase Memory Test Controller

This block drives a march-style test of a 36-bit-wide synchronous single-port memory. Each memory word is handled as three sub-words: two 16-bit halves and a 4-bit nibble. For every enabled data pattern the controller runs two phases over a programmable address window. In the first phase it writes a generated word to an address, reads that address back and checks the result. In the second phase it rewinds its pattern generator to the state saved when the pattern started, regenerates the same data sequence, and only reads and checks.

Each check is masked and is reported per sub-word and per phase. A mismatch normally stops the controller in a halt state that holds the failing address until a resume input is pulsed. Debug controls can pin the address, freeze the data word, or repeat one address forever (short loop). After every pattern type has been tried, a pass counter advances. When the configured number of passes is complete, a one-cycle done pulse is raised and the controller goes idle.

Top module: `memtest_ctrl`

## Requirements
- R1: A word is split as sub-word 0 = bits [15:0], sub-word 1 = bits [31:16] and sub-word 2 = bits [35:32]. Sub-word k fails when ((read XOR expected) AND cfg_mask) is nonzero within its bits; a 1 in cfg_mask marks a bit that is checked.
- R2: In phase 0, each address gets a write cycle (mem_we), then a read of the same address in the next cycle (mem_re). The read data is compared in the cycle after the read.
- R3: In phase 1 no write is issued. The generator restarts from the state saved at pattern start and the checker phase restarts, so a healthy memory gives no mismatch.
- R4: The pattern values are as follows. Zeros gives all bits 0. Ones gives all 36 bits 1. Checker alternates 36'hA_AAAA_AAAA and 36'h5_5555_5555, starting with the A value at each phase start.
- R5: The random pattern uses a 16-bit state x, seeded to 83 at reset and updated by x' = (2053·x + 13849) mod 65536. Each word takes three steps x1, x2, x3, giving sub-word 0 = x1, sub-word 1 = x2, sub-word 2 = x3[3:0].
- R6: Pattern types are visited in the order zeros, ones, checker, random, selected by cfg_pat_en bits 0, 1, 2 and 3. A type whose bit is 0 is skipped.
- R7: err_flags bits 0 to 2 mark sub-words 0 to 2 failing in phase 0, and bits 3 to 5 mark the same in phase 1. On a mismatch with cfg_short_loop low, halted rises and err_addr holds the failing address. Both stay stable until resume, after which the test continues at the next step.
- R8: With cfg_addr_hold = 1 the address does not advance. Every access stays at the window's low address.
- R9: With cfg_regen = 0 the word generated at phase start is reused for every address of the phase. With cfg_regen = 1 a new word is generated for each address.
- R10: With cfg_short_loop = 1 the current address is retested forever with the same data. A mismatch updates err_flags but does not halt.
- R11: After all four pattern slots the pass count increments. When it exceeds cfg_max_pass (that is, after cfg_max_pass+1 passes) done pulses for exactly one cycle, the count clears and the controller idles.
- R12: A phase ends when the next address would exceed cfg_high. Addresses above cfg_high are never accessed.
- R13: mem_we and mem_re are never high together, every access lies inside [cfg_low, cfg_high], and both strobes are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a test run from idle |
| resume | input | 1 | Leaves the halt state and continues |
| cfg_low | input | 12 | First address of the window |
| cfg_high | input | 12 | Last address of the window |
| cfg_mask | input | 36 | Compare mask, 1 = bit checked |
| cfg_pat_en | input | 4 | Pattern enables: zeros, ones, checker, random (bit 0 up) |
| cfg_addr_hold | input | 1 | Keep the address fixed |
| cfg_regen | input | 1 | Generate a new word for every address |
| cfg_short_loop | input | 1 | Retest the current address indefinitely |
| cfg_max_pass | input | 8 | Pass limit; cfg_max_pass+1 passes run |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 36 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data valid next cycle |
| mem_rdata | input | 36 | Memory read data |
| err_flags | output | 6 | Per-phase, per-sub-word mismatch of the latest compare |
| err_addr | output | 12 | Address of the latest mismatch |
| halted | output | 1 | Stopped on a mismatch |
| done | output | 1 | One-cycle pulse at the end of the run |

## Verification
The assertions assume that the configuration does not change while a run is in progress and that cfg_low is not greater than cfg_high. They also assume the memory keeps its read output stable until the next read strobe. The bench changes configuration only after a reset and before start. Its memory model registers read data only on mem_re. Faults are injected by flipping chosen bits of the read data for one address, so the memory contents themselves stay intact.

// File: rtl/mtc_pkg.sv
// Shared constants and types for the memory test controller.
package mtc_pkg;
    localparam int NUM_PAT = 4;   // pattern types visited per pass
    localparam int NUM_SUB = 3;   // sub-words per memory word

    typedef enum logic [1:0] {
        PAT_ZERO  = 2'd0,
        PAT_ONES  = 2'd1,
        PAT_CHECK = 2'd2,
        PAT_RAND  = 2'd3
    } pat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_FILL,
        ST_WRITE,
        ST_READ,
        ST_CMP,
        ST_HALT
    } state_t;
endpackage

// File: rtl/mtc_patgen.sv
// Test word generator.
// Produces one word per step for the selected pattern type. Holds a 16-bit
// linear congruential state that can be saved and later rewound, plus a
// checker phase bit. Assumes save, rewind and step are never asserted in
// the same cycle.
module mtc_patgen
    import mtc_pkg::*;
#(
    parameter int SUB_W   = 16,
    parameter int TOP_W   = 4,
    parameter int LCG_MUL = 2053,
    parameter int LCG_INC = 13849,
    parameter int SEED    = 83
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  pat_t                     pat,
    input  logic                     save,
    input  logic                     rewind,
    input  logic                     step,
    output logic [2*SUB_W+TOP_W-1:0] word
);
    localparam int WORD_W = 2*SUB_W + TOP_W;
    localparam logic [SUB_W-1:0] MUL_C = SUB_W'(LCG_MUL);
    localparam logic [SUB_W-1:0] INC_C = SUB_W'(LCG_INC);
    localparam logic [SUB_W-1:0] SEED_C = SUB_W'(SEED);
    localparam logic [SUB_W-1:0] CHK_A = {(SUB_W/2){2'b10}};
    localparam logic [SUB_W-1:0] CHK_B = {(SUB_W/2){2'b01}};

    logic [SUB_W-1:0]  xa, xa_saved, x1, x2, x3, chk;
    logic              toggle;
    logic [WORD_W-1:0] next_word;

    function automatic logic [SUB_W-1:0] lcg_next(input logic [SUB_W-1:0] x);
        return x * MUL_C + INC_C;
    endfunction

    // Three chained generator steps feed one random word.
    always_comb begin
        x1  = lcg_next(xa);
        x2  = lcg_next(x1);
        x3  = lcg_next(x2);
        chk = toggle ? CHK_B : CHK_A;
    end

    // Select the word for the active pattern type.
    always_comb begin
        case (pat)
            PAT_ZERO:  next_word = '0;
            PAT_ONES:  next_word = '1;
            PAT_CHECK: next_word = {chk[TOP_W-1:0], chk, chk};
            default:   next_word = {x3[TOP_W-1:0], x2, x1};
        endcase
    end

    // Generator state: save, rewind or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa       <= SEED_C;
            xa_saved <= SEED_C;
            toggle   <= 1'b0;
            word     <= '0;
        end else if (save) begin
            xa_saved <= xa;
            toggle   <= 1'b0;
        end else if (rewind) begin
            xa     <= xa_saved;
            toggle <= 1'b0;
        end else if (step) begin
            word <= next_word;
            if (pat == PAT_RAND)  xa     <= x3;
            if (pat == PAT_CHECK) toggle <= ~toggle;
        end
    end

    // R3: the controller never requests a save and a replay together.
    p_save_rewind_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(save && rewind));
endmodule

// File: rtl/mtc_cmp.sv
// Masked sub-word comparator.
// Flags each sub-word whose checked bits differ between read and expected
// data. Purely combinational; assumes the read data is valid when used.
module mtc_cmp
    import mtc_pkg::*;
#(
    parameter int SUB_W = 16,
    parameter int TOP_W = 4
) (
    input  logic [2*SUB_W+TOP_W-1:0] rdata,
    input  logic [2*SUB_W+TOP_W-1:0] expect_w,
    input  logic [2*SUB_W+TOP_W-1:0] mask,
    output logic [NUM_SUB-1:0]       miss
);
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        localparam int LO = g * SUB_W;
        localparam int W  = (g < NUM_SUB-1) ? SUB_W : TOP_W;
        // One reduction per sub-word slice.
        assign miss[g] = |((rdata[LO +: W] ^ expect_w[LO +: W]) & mask[LO +: W]);
    end
endmodule

// File: rtl/memtest_ctrl.sv
// Two-phase memory test controller.
// Walks an address window once per enabled pattern, first writing and
// reading back, then replaying the generator for a read-only check. Assumes
// configuration is stable during a run, cfg_low <= cfg_high, and a memory
// with one cycle of read latency whose output holds until the next read.
module memtest_ctrl
    import mtc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SUB_W  = 16,
    parameter int TOP_W  = 4,
    parameter int PASS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     resume,
    input  logic [ADDR_W-1:0]        cfg_low,
    input  logic [ADDR_W-1:0]        cfg_high,
    input  logic [2*SUB_W+TOP_W-1:0] cfg_mask,
    input  logic [NUM_PAT-1:0]       cfg_pat_en,
    input  logic                     cfg_addr_hold,
    input  logic                     cfg_regen,
    input  logic                     cfg_short_loop,
    input  logic [PASS_W-1:0]        cfg_max_pass,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [2*SUB_W+TOP_W-1:0] mem_wdata,
    output logic                     mem_we,
    output logic                     mem_re,
    input  logic [2*SUB_W+TOP_W-1:0] mem_rdata,
    output logic [2*NUM_SUB-1:0]     err_flags,
    output logic [ADDR_W-1:0]        err_addr,
    output logic                     halted,
    output logic                     done
);
    localparam int IDX_W = $clog2(NUM_PAT + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_PAT);

    state_t              state;
    logic                phase;
    logic [IDX_W-1:0]    pat_idx;
    logic [PASS_W-1:0]   pass_cnt;
    logic [ADDR_W-1:0]   addr;
    logic [NUM_SUB-1:0]  miss;
    logic [ADDR_W:0]     addr_nx;
    logic                at_end, advance, pick_now, pass_last;
    logic                gen_save, gen_rewind, gen_step;

    mtc_patgen #(.SUB_W(SUB_W), .TOP_W(TOP_W)) i_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .pat    (pat_t'(pat_idx[1:0])),
        .save   (gen_save),
        .rewind (gen_rewind),
        .step   (gen_step),
        .word   (mem_wdata)
    );

    mtc_cmp #(.SUB_W(SUB_W), .TOP_W(TOP_W)) i_cmp (
        .rdata    (mem_rdata),
        .expect_w (mem_wdata),
        .mask     (cfg_mask),
        .miss     (miss)
    );

    // Step decisions shared by the sequencer and the generator controls.
    always_comb begin
        addr_nx    = {1'b0, addr} + {{ADDR_W{1'b0}}, ~cfg_addr_hold};
        at_end     = addr_nx > {1'b0, cfg_high};
        advance    = (state == ST_CMP && !cfg_short_loop && miss == '0) ||
                     (state == ST_HALT && resume);
        pick_now   = state == ST_PICK && pat_idx != IDX_END && cfg_pat_en[pat_idx[1:0]];
        pass_last  = ({1'b0, pass_cnt} + 1'b1) > {1'b0, cfg_max_pass};
        gen_save   = pick_now;
        gen_rewind = advance && at_end && !phase;
        gen_step   = state == ST_FILL;
    end

    assign mem_addr = addr;
    assign mem_we   = state == ST_WRITE;
    assign mem_re   = state == ST_READ;
    assign halted   = state == ST_HALT;

    // Main sequencer: pattern choice, phase walk, compare and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= 1'b0;
            pat_idx   <= '0;
            pass_cnt  <= '0;
            addr      <= '0;
            err_flags <= '0;
            err_addr  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    pat_idx   <= '0;
                    pass_cnt  <= '0;
                    err_flags <= '0;
                    state     <= ST_PICK;
                end
                ST_PICK: begin
                    if (pat_idx == IDX_END) begin
                        pat_idx <= '0;
                        if (pass_last) begin
                            pass_cnt <= '0;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            pass_cnt <= pass_cnt + 1'b1;
                        end
                    end else if (pick_now) begin
                        addr  <= cfg_low;
                        phase <= 1'b0;
                        state <= ST_FILL;
                    end else begin
                        pat_idx <= pat_idx + 1'b1;
                    end
                end
                ST_FILL:  state <= phase ? ST_READ : ST_WRITE;
                ST_WRITE: state <= ST_READ;
                ST_READ:  state <= ST_CMP;
                ST_CMP: begin
                    err_flags <= phase ? {miss, {NUM_SUB{1'b0}}} : {{NUM_SUB{1'b0}}, miss};
                    if (miss != '0) err_addr <= addr;
                    if (cfg_short_loop)  state <= phase ? ST_READ : ST_WRITE;
                    else if (miss != '0) state <= ST_HALT;
                end
                default: ;
            endcase
            if (advance) begin
                if (at_end) begin
                    addr <= cfg_low;
                    if (!phase) begin
                        phase <= 1'b1;
                        state <= ST_FILL;
                    end else begin
                        pat_idx <= pat_idx + 1'b1;
                        state   <= ST_PICK;
                    end
                end else begin
                    addr <= addr_nx[ADDR_W-1:0];
                    if (cfg_regen) state <= ST_FILL;
                    else           state <= phase ? ST_READ : ST_WRITE;
                end
            end
        end
    end

    // R13: the two strobes never overlap.
    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R13: every access stays inside the configured window (R12 end bound).
    p_in_window_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr >= cfg_low && mem_addr <= cfg_high));
    // R2: a write is followed by a read of the same address.
    p_write_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_re && $stable(mem_addr)));
    // R3: the replay phase never writes.
    p_replay_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> !mem_we);
    // R7: a halt holds its report until resume.
    p_halt_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> (halted && $stable(err_addr) && $stable(err_flags)));
    // R7: flags of only one phase are ever raised together.
    p_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[NUM_SUB-1:0] != '0) |-> (err_flags[2*NUM_SUB-1:NUM_SUB] == '0));
    // R11: done lasts a single cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/test_memtest_ctrl.sv
`timescale 1ns/1ps
module test_memtest_ctrl;
    localparam int AW = 12;
    localparam int WW = 36;
    localparam logic [WW-1:0] ONES = 36'hF_FFFF_FFFF;
    localparam logic [WW-1:0] CHKA = 36'hA_AAAA_AAAA;
    localparam logic [WW-1:0] CHKB = 36'h5_5555_5555;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, resume = 1'b0;
    logic [AW-1:0] cfg_low = '0, cfg_high = '0;
    logic [WW-1:0] cfg_mask = ONES;
    logic [3:0]    cfg_pat_en = '0;
    logic          cfg_addr_hold = 1'b0, cfg_regen = 1'b1, cfg_short_loop = 1'b0;
    logic [7:0]    cfg_max_pass = '0;
    logic [AW-1:0] mem_addr, err_addr;
    logic [WW-1:0] mem_wdata, mem_rdata;
    logic          mem_we, mem_re, halted, done;
    logic [5:0]    err_flags;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    memtest_ctrl i_memtest_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_mask(cfg_mask),
        .cfg_pat_en(cfg_pat_en), .cfg_addr_hold(cfg_addr_hold),
        .cfg_regen(cfg_regen), .cfg_short_loop(cfg_short_loop),
        .cfg_max_pass(cfg_max_pass), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .err_flags(err_flags), .err_addr(err_addr), .halted(halted), .done(done)
    );

    // Memory model with read fault injection on one address.
    logic [WW-1:0] ram [256];
    logic [WW-1:0] ram_q = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          fault_on = 1'b0;
    logic [AW-1:0] fault_addr = '0;
    logic [WW-1:0] fault_bits = '0;
    logic [AW-1:0] watch_addr = '0;
    int wr_cnt = 0, rd_cnt = 0, off_cnt = 0, done_cnt = 0;

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) begin
            ram_q   <= ram[mem_addr[7:0]];
            rd_addr <= mem_addr;
            rd_cnt  <= rd_cnt + 1;
        end
        if ((mem_we || mem_re) && mem_addr != watch_addr) off_cnt <= off_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
    end
    assign mem_rdata = ram_q ^ ((fault_on && rd_addr == fault_addr) ? fault_bits : '0);

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lcg(input logic [15:0] x);
        return 16'(x * 16'd2053 + 16'd13849);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; resume = 1'b0; fault_on = 1'b0;
        cfg_mask = ONES; cfg_addr_hold = 1'b0; cfg_regen = 1'b1;
        cfg_short_loop = 1'b0; cfg_max_pass = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                         input logic [3:0] pats);
        do_reset();
        cfg_low = lo; cfg_high = hi; cfg_pat_en = pats; watch_addr = lo;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Runs until done, resuming on every halt and logging the first two.
    task automatic run_to_done(input string req, output int halts,
                               output logic [5:0] f0, output logic [5:0] f1,
                               output logic [AW-1:0] a0, output logic [AW-1:0] a1);
        bit seen = 0;
        halts = 0; f0 = '0; f1 = '0; a0 = '0; a1 = '0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
            if (halted) begin
                if (halts == 0) begin f0 = err_flags; a0 = err_addr; end
                if (halts == 1) begin f1 = err_flags; a1 = err_addr; end
                halts++;
                resume = 1'b1;
                @(negedge clk);
                resume = 1'b0;
            end
        end
        check(seen, req, 64'(seen), 64'd1);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(!mem_we && !mem_re, "R13 reset strobes", {62'd0, mem_we, mem_re}, 0);
        check(!done && !halted && err_flags == 0, "R7 reset status",
              {56'd0, done, halted, err_flags}, 0);
    endtask

    task automatic t_zero_ones();
        int h, w0, r0; logic [5:0] f0, f1; logic [AW-1:0] a0, a1; logic [WW-1:0] above;
        setup(12'h010, 12'h013, 4'b0011);
        above = ram[8'h14]; w0 = wr_cnt; r0 = rd_cnt;
        kick();
        run_to_done("R11 done zeros/ones", h, f0, f1, a0, a1);
        check(h == 0, "R3 no mismatch zeros/ones", 64'(h), 0);
        check(wr_cnt - w0 == 8, "R2 one write per address per pattern", 64'(wr_cnt - w0), 8);
        check(rd_cnt - r0 == 16, "R3 reads in both phases", 64'(rd_cnt - r0), 16);
        for (int a = 'h10; a <= 'h13; a++)
            check(ram[a] == ONES, "R6 ones written after zeros", 64'(ram[a]), 64'(ONES));
        check(ram[8'h14] === above, "R12 no access above window", 64'(ram[8'h14]), 64'(above));
    endtask

    task automatic t_checker();
        int h; logic [5:0] f0, f1; logic [AW-1:0] a0, a1;
        setup(12'h020, 12'h023, 4'b0100);
        kick();
        run_to_done("R11 done checker", h, f0, f1, a0, a1);
        check(h == 0, "R3 checker replay", 64'(h), 0);
        for (int a = 0; a < 4; a++) begin
            logic [WW-1:0] e = (a % 2 == 0) ? CHKA : CHKB;
            check(ram[8'h20 + a] == e, "R4 checker alternation", 64'(ram[8'h20 + a]), 64'(e));
        end
    endtask

    task automatic t_random(input bit regen);
        int h; logic [5:0] f0, f1; logic [AW-1:0] a0, a1;
        logic [15:0] x = 16'd83, x1, x2, x3; logic [WW-1:0] e;
        setup(12'h030, 12'h032, 4'b1000);
        cfg_regen = regen;
        kick();
        run_to_done("R11 done random", h, f0, f1, a0, a1);
        check(h == 0, "R3 random replay", 64'(h), 0);
        for (int a = 0; a < 3; a++) begin
            if (a == 0 || regen) begin
                x1 = lcg(x); x2 = lcg(x1); x3 = lcg(x2); x = x3;
                e = {x3[3:0], x2, x1};
            end
            check(ram[8'h30 + a] == e, regen ? "R5 random word" : "R9 word reused",
                  64'(ram[8'h30 + a]), 64'(e));
        end
    endtask

    task automatic t_fault(input logic [AW-1:0] fa, input logic [WW-1:0] fb,
                           input logic [WW-1:0] msk, input int exp_halts,
                           input logic [5:0] ef0, input logic [5:0] ef1);
        int h; logic [5:0] f0, f1; logic [AW-1:0] a0, a1;
        setup(12'h040, 12'h043, 4'b0001);
        cfg_mask = msk; fault_on = 1'b1; fault_addr = fa; fault_bits = fb;
        kick();
        run_to_done("R7 resume continues to done", h, f0, f1, a0, a1);
        check(h == exp_halts, "R1 masked mismatch count", 64'(h), 64'(exp_halts));
        if (exp_halts == 2) begin
            check(f0 == ef0 && a0 == fa, "R7 phase 0 flag/addr", {f0, a0}, {ef0, fa});
            check(f1 == ef1 && a1 == fa, "R7 phase 1 flag/addr", {f1, a1}, {ef1, fa});
        end
    endtask

    task automatic t_hold();
        int w0, o0, d0;
        setup(12'h050, 12'h052, 4'b0001);
        cfg_addr_hold = 1'b1;
        w0 = wr_cnt; o0 = off_cnt; d0 = done_cnt;
        kick();
        repeat (60) @(negedge clk);
        check(wr_cnt - w0 >= 5, "R8 writes keep coming", 64'(wr_cnt - w0), 5);
        check(off_cnt == o0 && done_cnt == d0, "R8 address held",
              64'(off_cnt - o0), 0);
    endtask

    task automatic t_short();
        int w0, o0; bit any_halt = 0;
        setup(12'h060, 12'h062, 4'b0001);
        cfg_short_loop = 1'b1; fault_on = 1'b1; fault_addr = 12'h060; fault_bits = 36'h1;
        w0 = wr_cnt; o0 = off_cnt;
        kick();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (halted) any_halt = 1;
        end
        check(wr_cnt - w0 >= 5 && off_cnt == o0, "R10 same address repeated",
              64'(off_cnt - o0), 0);
        check(!any_halt, "R10 no halt in short loop", 64'(any_halt), 0);
        check(err_flags == 6'b000001, "R10 flags still reported", 64'(err_flags), 1);
    endtask

    task automatic t_passes();
        int h, w0, d0; logic [5:0] f0, f1; logic [AW-1:0] a0, a1;
        setup(12'h070, 12'h071, 4'b0001);
        cfg_max_pass = 8'd2;
        w0 = wr_cnt; d0 = done_cnt;
        kick();
        run_to_done("R11 done after passes", h, f0, f1, a0, a1);
        check(wr_cnt - w0 == 6, "R11 three passes run", 64'(wr_cnt - w0), 6);
        @(negedge clk);
        check(!done, "R11 done one cycle", 64'(done), 0);
        repeat (20) @(negedge clk);
        check(done_cnt - d0 == 1 && !mem_we && !mem_re, "R11 idle after done",
              64'(done_cnt - d0), 1);
    endtask

    task automatic t_skip_all();
        int h, w0; logic [5:0] f0, f1; logic [AW-1:0] a0, a1;
        setup(12'h078, 12'h079, 4'b0000);
        w0 = wr_cnt;
        kick();
        run_to_done("R6 done with no pattern", h, f0, f1, a0, a1);
        check(wr_cnt == w0, "R6 disabled types skipped", 64'(wr_cnt - w0), 0);
    endtask

    initial begin
        t_reset();
        t_zero_ones();
        t_checker();
        t_random(1'b1);
        t_random(1'b0);
        t_fault(12'h041, 36'h0_0010_0000, ONES, 2, 6'b000010, 6'b010000);  // R1 sub-word 1
        t_fault(12'h042, 36'h2_0000_0000, ONES, 2, 6'b000100, 6'b100000);  // R1 sub-word 2
        t_fault(12'h041, 36'h0_0010_0000, ONES ^ 36'h0_0010_0000, 0, 0, 0); // R1 masked bit
        t_hold();
        t_short();
        t_passes();
        t_skip_all();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule